// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a memory-mapped watchdog. Software sets it up with one write to a control word. That word holds a 16-bit reload count, a prescale select, an enable, a choice between raising an interrupt and requesting a system reset on expiry, and a freeze select. The freeze select lets a debug halt stop the count. After a power-on reset the control word takes exactly one write. Every later write is dropped, so an enable, or a decision to leave the timer off, cannot be changed until the next power-on.

Software keeps the timer from expiring by writing an ordered pair of 16-bit keys to the service register. Only the complete pair reloads the counter. When the count runs out, the block does one of two things. It can raise an interrupt, which stays high until the next complete service pair. Or it can drive a reset request for a fixed number of clocks and set a sticky flag recording that the watchdog caused the reset. Software clears that flag by writing one to it. The block's own power-on reset is separate from the reset it requests, so the flag survives that reset.

Top module: `wdt_lock_top`

## Requirements
- R1: After reset, both outputs are low and reads of the reserved, control, count and status words return 0.
- R2: Only the first control write after reset takes effect, whatever its content. Control readback shows the value in effect: reload in bits 31:16, freeze bit 3, enable bit 2, reset-select bit 1, prescale bit 0. All other bits read 0.
- R3: With prescale clear and the timer enabled, the count drops by one every clock. The accepted control write loads the count from the reload field. A disabled timer holds its count.
- R4: With prescale set, the count drops by one every 65536 clocks, counted from the load.
- R5: A write of 0x556C followed directly by a write of 0xAA39 to the service word (bits 15:0) reloads the count. Any other service write sends the tracker back to waiting for 0x556C, and the 0xAA39 that follows it does not reload.
- R6: The timer expires on a count step taken while the count is 0, and the count then reloads. With reset-select 0, the interrupt rises at expiry and stays high until a complete service pair.
- R7: With reset-select 1, expiry drives the reset request high for exactly 16 clocks, and the interrupt stays low. An expiry during an active pulse is absorbed.
- R8: A reset-mode expiry sets status bit 0. Writing 1 to bit 0 clears it. Writing 0 leaves it set.
- R9: While freeze is set and the debug-halt input is high, the count holds. With halt low, it counts normally.
- R10: The word offsets are 0x00 reserved (reads 0), 0x04 control, 0x08 count (bits 15:0), 0x0C service (the big-endian halfword at byte 0xE, in bits 15:0) and 0x10 status. Read data and its valid flag appear one clock after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_re |
| dbg_halt | input | 1 | Debug halt; stops the count when freeze is set |
| wdt_irq | output | 1 | Expiry interrupt, level |
| wdt_rst_req | output | 1 | Reset request pulse |

## Verification
The hardest case to reach is the prescaled step. It happens only once every 65536 clocks, and a one-cycle error in the prescaler looks the same as a correct design unless the count is read on both sides of the exact step edge. The bench therefore times its reads from the control write, one clock at a time, and reads the count in the clock just before the step and again just after it. A second awkward case is a broken key pair. The bench sends the keys with a wrong key between them, and also sends the first key twice. In each case it reads back a count that has kept falling, which shows that no reload happened.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;
  localparam int CNT_W = 16;
  localparam logic [7:0] OFS_RSVD  = 8'h00;
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_COUNT = 8'h08;
  localparam logic [7:0] OFS_SVC   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [15:0] KEY_ARM  = 16'h556C;
  localparam logic [15:0] KEY_FIRE = 16'hAA39;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic             freeze;
    logic             enable;
    logic             sel_rst;
    logic             presc;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_lock_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire_rst,
  output ctrl_t             ctrl,
  output logic              ctrl_load,
  output logic [CNT_W-1:0]  load_val,
  output logic              svc_we,
  output logic [15:0]       svc_key,
  output logic              stat,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  logic locked;

  assign ctrl_load = we && (addr == ADDR_W'(OFS_CTRL)) && !locked;
  assign load_val  = wdata[31:16];
  assign svc_we    = we && (addr == ADDR_W'(OFS_SVC));
  assign svc_key   = wdata[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      ctrl   <= '0;
    end else if (ctrl_load) begin
      locked <= 1'b1;
      ctrl   <= '{reload: wdata[31:16], freeze: wdata[3], enable: wdata[2],
                  sel_rst: wdata[1], presc: wdata[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      stat <= 1'b0;
    else if (expire_rst)
      stat <= 1'b1;
    else if (we && (addr == ADDR_W'(OFS_STAT)) && wdata[0])
      stat <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) begin
        case (addr)
          ADDR_W'(OFS_CTRL):  rdata <= {ctrl.reload, 12'b0, ctrl.freeze, ctrl.enable,
                                        ctrl.sel_rst, ctrl.presc};
          ADDR_W'(OFS_COUNT): rdata <= {{(32-CNT_W){1'b0}}, count};
          ADDR_W'(OFS_STAT):  rdata <= {31'b0, stat};
          default:            rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
  import wdt_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        svc_we,
  input  logic [15:0] svc_key,
  output logic        svc_done
);
  logic armed;

  assign svc_done = svc_we && armed && (svc_key == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (svc_we)
      armed <= !armed && (svc_key == KEY_ARM);
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_lock_pkg::*;
#(
  parameter int PRE_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             ctrl_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             svc_done,
  input  logic             dbg_halt,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             rst_req,
  output logic             expire_rst
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic            reload_now, run, pre_full, tick, expire;
  logic [PC_W-1:0] pulse_cnt;

  assign reload_now = ctrl_load || svc_done;
  assign run        = ctrl.enable && !(ctrl.freeze && dbg_halt);
  assign tick       = run && (!ctrl.presc || pre_full);
  assign expire     = tick && (count == '0) && !reload_now;
  assign expire_rst = expire && ctrl.sel_rst;

  generate
    if (PRE_W > 0) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || reload_now)
          pre_q <= '0;
        else if (run)
          pre_q <= pre_q + 1'b1;
      end
      assign pre_full = &pre_q;
    end else begin : g_nopre
      assign pre_full = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (ctrl_load)
      count <= load_val;
    else if (svc_done || expire)
      count <= ctrl.reload;
    else if (tick)
      count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else if (svc_done)
      irq <= 1'b0;
    else if (expire && !ctrl.sel_rst)
      irq <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req   <= 1'b0;
      pulse_cnt <= '0;
    end else if (expire_rst && (!rst_req || pulse_cnt == '0)) begin
      rst_req   <= 1'b1;
      pulse_cnt <= PC_W'(PULSE_LEN - 1);
    end else if (pulse_cnt != '0) begin
      pulse_cnt <= pulse_cnt - 1'b1;
    end else begin
      rst_req   <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_lock_top.sv
module wdt_lock_top
  import wdt_lock_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int PRE_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              dbg_halt,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  ctrl_t            ctrl;
  logic             ctrl_load, svc_we, svc_done, expire_rst, stat;
  logic [15:0]      svc_key;
  logic [CNT_W-1:0] load_val, count;

  wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .expire_rst(expire_rst), .ctrl(ctrl),
    .ctrl_load(ctrl_load), .load_val(load_val), .svc_we(svc_we),
    .svc_key(svc_key), .stat(stat), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  wdt_svc_seq u_svc (
    .clk(clk), .rst(rst), .svc_we(svc_we), .svc_key(svc_key), .svc_done(svc_done)
  );

  wdt_core #(.PRE_W(PRE_W), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl), .ctrl_load(ctrl_load),
    .load_val(load_val), .svc_done(svc_done), .dbg_halt(dbg_halt),
    .count(count), .irq(wdt_irq), .rst_req(wdt_rst_req), .expire_rst(expire_rst)
  );
endmodule

// File: rtl/wdt_lock_checker.sv
module wdt_lock_checker
  import wdt_lock_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rst,
  input ctrl_t            ctrl,
  input logic             ctrl_load,
  input logic             svc_done,
  input logic             dbg_halt,
  input logic [CNT_W-1:0] count,
  input logic             irq,
  input logic             rst_req,
  input logic             stat
);
  logic        seen;
  logic [31:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= 1'b0;
      hi_cnt <= '0;
    end else begin
      if (ctrl_load) seen <= 1'b1;
      hi_cnt <= rst_req ? hi_cnt + 1 : '0;
    end
  end

  a_r2_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
    (seen && !ctrl_load) |=> $stable(ctrl));
  a_r3_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    (seen && !ctrl.enable && !svc_done && !ctrl_load) |=> $stable(count));
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !svc_done) |=> irq);
  a_r6_irq_clear: assert property (@(posedge clk) disable iff (rst)
    svc_done |=> !irq);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq, rst_req}));
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_req) |-> (hi_cnt != 0 && (hi_cnt % PULSE_LEN) == 0));
  a_r8_status_set: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> stat);
  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl.freeze && dbg_halt && !svc_done && !ctrl_load) |=> (count == $past(count)));
endmodule

bind wdt_lock_top wdt_lock_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .ctrl_load(ctrl_load), .svc_done(svc_done),
  .dbg_halt(dbg_halt), .count(count), .irq(wdt_irq), .rst_req(wdt_rst_req),
  .stat(stat)
);

// File: tb/wdt_lock_top_tb.sv
`timescale 1ns/1ps
module wdt_lock_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0, dbg_halt = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, wdt_irq, wdt_rst_req;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [4:0] A_RSVD = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08,
                         A_SVC = 5'h0C, A_STAT = 5'h10;

  always #2.5 clk = ~clk;

  wdt_lock_top u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dbg_halt(dbg_halt), .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each returned read with the next queued expectation
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hxxxx_xxxx, "R10 unexpected rvalid");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; dbg_halt = 1'b0;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic count_high(input int win, output int hi);
    hi = 0;
    repeat (win) begin
      @(negedge clk);
      if (wdt_rst_req) hi++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int hi;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check({31'b0, wdt_irq}, 0, "R1 irq after reset");
    check({31'b0, wdt_rst_req}, 0, "R1 rst_req after reset");
    rd(A_RSVD, 0, "R1 reserved read");
    rd(A_CTRL, 0, "R1 control read");
    rd(A_CNT, 0, "R1 count read");
    rd(A_STAT, 0, "R1 status read");

    // R2/R3/R10: disabled first write locks the timer off
    wr(A_CTRL, 32'h0020_FFF0);
    wr(A_CTRL, 32'h0020_0004);
    rd(A_CTRL, 32'h0020_0000, "R2 first write kept, masked");
    idle(40);
    rd(A_CNT, 32'd32, "R3 disabled count holds");
    rd(A_RSVD, 0, "R10 reserved reads zero");
    check({31'b0, wdt_irq}, 0, "R3 disabled no irq");

    // R3/R5/R6: interrupt mode, T=100
    do_reset();
    wr(A_CTRL, 32'h0064_0004);                 // E0
    rd(A_CNT, 32'd100, "R3 loaded by control write");   // E1
    idle(9);
    rd(A_CNT, 32'd90, "R3 one step per clock");  // E11
    wr(A_SVC, 32'h0000_556C); wr(A_SVC, 32'h0000_AA39);
    rd(A_CNT, 32'd100, "R5 key pair reloads");   // E14
    wr(A_SVC, 32'h0000_556C); wr(A_SVC, 32'h0000_1234); wr(A_SVC, 32'h0000_AA39);
    rd(A_CNT, 32'd96, "R5 wrong key breaks pair"); // E18
    wr(A_SVC, 32'h0000_556C); wr(A_SVC, 32'h0000_556C); wr(A_SVC, 32'h0000_AA39);
    rd(A_CNT, 32'd92, "R5 repeated first key breaks pair"); // E22
    idle(91);
    check({31'b0, wdt_irq}, 0, "R6 irq low before expiry");
    idle(1);
    check({31'b0, wdt_irq}, 1, "R6 irq at expiry");
    rd(A_CNT, 32'd100, "R6 reload at expiry");
    idle(300);
    check({31'b0, wdt_irq}, 1, "R6 irq stays high");
    check({31'b0, wdt_rst_req}, 0, "R6 no reset request in irq mode");
    wr(A_SVC, 32'h0000_556C); wr(A_SVC, 32'h0000_AA39);
    check({31'b0, wdt_irq}, 0, "R6 irq cleared by key pair");

    // R9: freeze with debug halt
    do_reset();
    wr(A_CTRL, 32'h00C8_000C);
    dbg_halt = 1'b1;
    rd(A_CNT, 32'd200, "R9 loaded");
    idle(20);
    rd(A_CNT, 32'd200, "R9 frozen while halted");
    dbg_halt = 1'b0;
    rd(A_CNT, 32'd200, "R9 release");
    idle(9);
    rd(A_CNT, 32'd190, "R9 counts after halt drops");

    // R7/R8/R2: reset mode, T=50
    do_reset();
    wr(A_CTRL, 32'h0032_0006);
    idle(50);
    check({31'b0, wdt_rst_req}, 0, "R7 no request before expiry");
    count_high(30, hi);
    check(hi, 16, "R7 pulse length");
    check({31'b0, wdt_irq}, 0, "R7 irq stays low");
    rd(A_STAT, 1, "R8 status set");
    wr(A_STAT, 0);
    rd(A_STAT, 1, "R8 write 0 keeps status");
    wr(A_STAT, 1);
    rd(A_STAT, 0, "R8 write 1 clears status");
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL, 32'h0032_0006, "R2 second write ignored");
    count_high(30, hi);
    check(hi, 16, "R2 R7 still enabled after ignored write");

    // R4: prescaled, T=1
    do_reset();
    wr(A_CTRL, 32'h0001_0005);
    rd(A_CNT, 32'd1, "R4 loaded");
    idle(65534);
    rd(A_CNT, 32'd1, "R4 no step before 65536 clocks");
    rd(A_CNT, 32'd0, "R4 step at 65536 clocks");
    idle(2);
    check(exp_q.size(), 0, "R10 every read returned");
    finish_run();
  end
endmodule